// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a parallel input port and requests attention from a host whenever any pin differs from a stored reference value. The request is an active-low, open-drain style line. It is modelled here as a single drive-low enable. When the enable is high, the pad pulls the shared line low. When it is low, the pad releases the line and never drives it high. Several devices can therefore share one interrupt wire.

The port pins arrive asynchronously and pass through a synchronizer before they are compared. The serial slave that sits beside this block supplies the bus clock and two strobes. The strobes are already synchronous to the system clock and mark the acknowledge bit of a read or a write addressed to this device. The request is withdrawn in one of two ways. Either the pins go back to the reference value, or the acknowledge edge of a transfer to this device arrives. That edge is the rising bus-clock edge for a read and the falling bus-clock edge for a write. At that same moment the reference is reloaded from the current pins.

Top module: `port_change_irq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `int_pull_low` is 0 and the reference value is all ones. With all pins held high after reset, no request appears.
- R2: Any single pin that differs from the reference raises the request, whether the pin went low (falling edge) or high (rising edge), for every pin position 0 to WIDTH-1.
- R3: A pin change applied between clock edges shows on `int_pull_low` after exactly three rising clock edges: two synchronizer stages plus the request register.
- R4: When the pins return to the reference value, the request drops three rising edges after that return, with no bus activity.
- R5: While `ack_rd` is 1, a 0-to-1 transition of `scl` seen at a clock edge clears the request at that edge and reloads the reference from the synchronized pins.
- R6: While `ack_wr` is 1, a 1-to-0 transition of `scl` seen at a clock edge clears the request at that edge and reloads the reference.
- R7: `scl` edges with both strobes at 0 have no effect on the request or on the reference. This is traffic for other devices. An `scl` falling edge during `ack_rd` and an `scl` rising edge during `ack_wr` also have no effect.
- R8: After a reload (R5/R6), a later change away from the new reference raises the request again. Returning to the new reference, not to all ones, clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | WIDTH | Asynchronous port pin levels |
| scl | input | 1 | Bus clock level, sampled in the clk domain (idle high) |
| ack_rd | input | 1 | High during the acknowledge bit of a read addressed to this device |
| ack_wr | input | 1 | High during the acknowledge bit of a write addressed to this device |
| int_pull_low | output | 1 | 1 = pull the shared interrupt line low; 0 = release it |

## Verification
A corrupted reference value shows as a request that never clears when the pins return, or as a spurious request with steady pins. This appears at `int_pull_low` three edges after the pins settle. A wrong acknowledge edge choice or strobe qualification shows in the very cycle of the bus-clock edge: the request either fails to drop or drops during traffic for another device. A missing reload shows one edge after that, when the request reappears with unchanged pins. The bench compares a behavioural model against the output on every clock, so each of these faults is caught within a few cycles of its cause.

// File: rtl/pci_pkg.sv
package pci_pkg;

    typedef enum logic [1:0] {
        ACK_NONE  = 2'd0,
        ACK_READ  = 2'd1,
        ACK_WRITE = 2'd2
    } ack_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } scl_edge_t;

    // Read strobe wins if the slave ever raises both.
    function automatic ack_kind_e ack_kind(input logic rd, input logic wr);
        if (rd)      return ACK_READ;
        else if (wr) return ACK_WRITE;
        else         return ACK_NONE;
    endfunction

    // Reads release on the rising bus-clock edge, writes on the falling one.
    function automatic logic clear_due(input ack_kind_e k, input scl_edge_t e);
        case (k)
            ACK_READ:  return e.rise;
            ACK_WRITE: return e.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pci_sync.sv
module pci_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam logic [WIDTH-1:0] IDLE_LVL = '1;

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= IDLE_LVL;
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= IDLE_LVL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pci_scl_track.sv
module pci_scl_track
    import pci_pkg::*;
#(
    parameter logic SCL_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic ack_rd,
    input  logic ack_wr,
    output logic clear_now
);
    logic      scl_q;
    scl_edge_t edge_s;

    always_ff @(posedge clk) begin
        if (rst) scl_q <= SCL_IDLE;
        else     scl_q <= scl;
    end

    always_comb begin
        edge_s.rise = scl & ~scl_q;
        edge_s.fall = ~scl & scl_q;
        clear_now   = clear_due(ack_kind(ack_rd, ack_wr), edge_s);
    end
endmodule

// File: rtl/pci_ref_cmp.sv
module pci_ref_cmp #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_s,
    input  logic             clear_now,
    output logic [WIDTH-1:0] ref_q,
    output logic             irq_q
);
    localparam logic [WIDTH-1:0] REF_INIT = '1;

    logic [WIDTH-1:0] diff;

    assign diff = pin_s ^ ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= REF_INIT;
            irq_q <= 1'b0;
        end else if (clear_now) begin
            ref_q <= pin_s;
            irq_q <= 1'b0;
        end else begin
            irq_q <= |diff;
        end
    end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] port_pins,
    input  logic             scl,
    input  logic             ack_rd,
    input  logic             ack_wr,
    output logic             int_pull_low
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] ref_val;
    logic             clear_now;
    logic             irq_q;

    pci_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (port_pins),
        .dout (pin_sync)
    );

    pci_scl_track #(.SCL_IDLE(1'b1)) u_scl (
        .clk       (clk),
        .rst       (rst),
        .scl       (scl),
        .ack_rd    (ack_rd),
        .ack_wr    (ack_wr),
        .clear_now (clear_now)
    );

    pci_ref_cmp #(.WIDTH(WIDTH)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pin_sync),
        .clear_now (clear_now),
        .ref_q     (ref_val),
        .irq_q     (irq_q)
    );

    assign int_pull_low = irq_q;
endmodule

// File: rtl/port_change_irq_checker.sv
module port_change_irq_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] pin_sync,
    input logic [WIDTH-1:0] ref_val,
    input logic             scl,
    input logic             ack_rd,
    input logic             ack_wr,
    input logic             int_pull_low
);
    logic scl_prev;
    logic rd_evt, wr_evt;

    always_ff @(posedge clk) begin
        if (rst) scl_prev <= 1'b1;
        else     scl_prev <= scl;
    end

    assign rd_evt = ack_rd && scl && !scl_prev;
    assign wr_evt = !ack_rd && ack_wr && !scl && scl_prev;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!int_pull_low && ref_val == '1));

    p_raise_r2: assert property (@(posedge clk) disable iff (rst)
        (pin_sync != ref_val && !rd_evt && !wr_evt) |=> int_pull_low);

    p_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(int_pull_low) |-> $past(pin_sync != ref_val));

    p_match_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_sync == ref_val) |=> !int_pull_low);

    p_rd_clear_r5: assert property (@(posedge clk) disable iff (rst)
        rd_evt |=> (!int_pull_low && ref_val == $past(pin_sync)));

    p_wr_clear_r6: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> (!int_pull_low && ref_val == $past(pin_sync)));

    p_ref_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_evt && !wr_evt) |=> $stable(ref_val));
endmodule

bind port_change_irq port_change_irq_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pin_sync     (pin_sync),
    .ref_val      (ref_val),
    .scl          (scl),
    .ack_rd       (ack_rd),
    .ack_wr       (ack_wr),
    .int_pull_low (int_pull_low)
);

// File: tb/port_change_irq_test.sv
`timescale 1ns/100ps
module port_change_irq_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pins = '1;
    logic         scl = 1'b1;
    logic         ack_rd = 1'b0;
    logic         ack_wr = 1'b0;
    logic         int_pull_low;

    int n_tests = 0;
    int n_fail  = 0;
    string tag = "R1";

    // behavioural model state
    logic [W-1:0] hist [$];
    logic [W-1:0] m_ref = '1;
    logic         m_int = 1'b0;
    logic         m_scl = 1'b1;

    always #2.5 clk = ~clk;

    port_change_irq #(.WIDTH(W), .SYNC_STAGES(2)) uut (
        .clk (clk), .rst (rst), .port_pins (pins), .scl (scl),
        .ack_rd (ack_rd), .ack_wr (ack_wr), .int_pull_low (int_pull_low)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: int_pull_low=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        hist = '{};
        hist.push_back('1);
        hist.push_back('1);
        m_ref = '1;
        m_int = 1'b0;
        m_scl = 1'b1;
    endfunction

    // one clock: drive at negedge, advance model at posedge, compare after it
    task automatic cyc(input logic [W-1:0] p, input logic s, input logic rd, input logic wr);
        logic [W-1:0] sync_now;
        logic         clr;
        @(negedge clk);
        pins = p; scl = s; ack_rd = rd; ack_wr = wr;
        @(posedge clk);
        sync_now = hist[0];
        clr = (rd && s && !m_scl) || (!rd && wr && !s && m_scl);
        if (rst) begin
            model_reset();
        end else begin
            if (clr) begin
                m_int = 1'b0;
                m_ref = sync_now;
            end else begin
                m_int = (sync_now != m_ref);
            end
            void'(hist.pop_front());
            hist.push_back(p);
            m_scl = s;
        end
        #1;
        check(tag, int_pull_low, m_int);
    endtask

    task automatic idle(input int n, input logic [W-1:0] p);
        for (int i = 0; i < n; i++) cyc(p, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state
        tag = "R1";
        rst = 1'b1;
        for (int i = 0; i < 3; i++) cyc('1, 1'b1, 1'b0, 1'b0);
        check("R1", int_pull_low, 1'b0);
        rst = 1'b0;
        idle(6, '1);
        check("R1", int_pull_low, 1'b0);

        // R2/R3/R4: each pin falls, exact latency, then returns
        for (int b = 0; b < W; b++) begin
            logic [W-1:0] v;
            v = '1; v[b] = 1'b0;
            tag = "R3";
            cyc(v, 1'b1, 1'b0, 1'b0);
            check("R3", int_pull_low, 1'b0);
            cyc(v, 1'b1, 1'b0, 1'b0);
            check("R3", int_pull_low, 1'b0);
            cyc(v, 1'b1, 1'b0, 1'b0);
            check("R2", int_pull_low, 1'b1);
            tag = "R4";
            cyc('1, 1'b1, 1'b0, 1'b0);
            cyc('1, 1'b1, 1'b0, 1'b0);
            check("R4", int_pull_low, 1'b1);
            cyc('1, 1'b1, 1'b0, 1'b0);
            check("R4", int_pull_low, 1'b0);
        end

        // R7: raise a request, then traffic for others and wrong edges
        tag = "R7";
        idle(4, 8'hA5);
        check("R7", int_pull_low, 1'b1);
        for (int i = 0; i < 6; i++) cyc(8'hA5, i[0], 1'b0, 1'b0);
        cyc(8'hA5, 1'b1, 1'b0, 1'b0);
        cyc(8'hA5, 1'b1, 1'b1, 1'b0);
        cyc(8'hA5, 1'b0, 1'b1, 1'b0);   // falling edge during read ack
        check("R7", int_pull_low, 1'b1);
        cyc(8'hA5, 1'b0, 1'b0, 1'b1);
        cyc(8'hA5, 1'b1, 1'b0, 1'b1);   // rising edge during write ack
        check("R7", int_pull_low, 1'b1);

        // R5: read ack clear on rising scl, reference reloaded to A5
        tag = "R5";
        cyc(8'hA5, 1'b0, 1'b1, 1'b0);
        check("R5", int_pull_low, 1'b1);
        cyc(8'hA5, 1'b1, 1'b1, 1'b0);
        check("R5", int_pull_low, 1'b0);
        idle(4, 8'hA5);
        check("R5", int_pull_low, 1'b0);

        // R8: rising edge on pin 1 vs new reference, then back to A5
        tag = "R8";
        idle(4, 8'hA7);
        check("R8", int_pull_low, 1'b1);
        idle(4, 8'hA5);
        check("R8", int_pull_low, 1'b0);

        // R6: write ack clear on falling scl
        tag = "R6";
        idle(4, 8'h3C);
        check("R6", int_pull_low, 1'b1);
        cyc(8'h3C, 1'b1, 1'b0, 1'b1);
        check("R6", int_pull_low, 1'b1);
        cyc(8'h3C, 1'b0, 1'b0, 1'b1);
        check("R6", int_pull_low, 1'b0);
        cyc(8'h3C, 1'b1, 1'b0, 1'b0);
        idle(4, 8'h3C);
        check("R6", int_pull_low, 1'b0);

        // R8: change right around the write clear re-raises the request
        tag = "R8";
        idle(4, 8'hFF);
        check("R8", int_pull_low, 1'b1);
        idle(4, 8'h3C);
        check("R8", int_pull_low, 1'b0);

        // R2: rising edges per pin against an all-zero reference
        idle(4, 8'h00);
        cyc(8'h00, 1'b0, 1'b1, 1'b0);
        cyc(8'h00, 1'b1, 1'b1, 1'b0);
        check("R5", int_pull_low, 1'b0);
        cyc(8'h00, 1'b1, 1'b0, 1'b0);
        for (int b = 0; b < W; b++) begin
            logic [W-1:0] v;
            v = '0; v[b] = 1'b1;
            tag = "R2";
            idle(3, v);
            check("R2", int_pull_low, 1'b1);
            tag = "R4";
            idle(3, 8'h00);
            check("R4", int_pull_low, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule